// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block turns up to 32 already-synchronized GPIO input lines into interrupt requests. Each line picks level or edge sensitivity and an active polarity. A separate dual-edge setting makes the line fire on both transitions and takes priority over the type and polarity settings. Edge events are held in a per-line latch until software acknowledges them. Level conditions are not latched: they follow the input.

Every per-line configuration word has one write address that sets bits and another that clears them, so one line can be changed without a read-modify-write. A line reaches the status word only while it is enabled and unmasked. A single registered interrupt output is raised when any status bit is set, and a combine-enable register gates that output. The register port is a plain single-cycle write and a combinational read. Any bus bridge sits outside the block.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration bit and the combine enable are 0. The status word (read address 0x070) reads 0, the dual-edge readback (0x0b8) reads 0, and irq_o is 0.
- R2: Configuration words are written through address pairs. A write to the set address sets the bits where wdata is 1, and a write to the clear address clears them. Bits where wdata is 0 keep their value. The pairs are: enable 0x020/0x024, mask 0x030/0x034, type 0x040/0x044, polarity 0x050/0x054, dual-edge 0x0b0/0x0b4. The dual-edge word reads back at 0x0b8.
- R3: With type bit 0 (level) and dual-edge off, the line's status follows the input in the same cycle: polarity 1 is active when the input is high, polarity 0 when it is low. Nothing is latched.
- R4: With type bit 1 (edge) and dual-edge off, polarity 1 latches on a rising edge and polarity 0 on a falling edge. The status bit appears in the cycle after the clock edge that samples the transition. The latch holds until it is acknowledged, and the opposite edge has no effect on it.
- R5: While a line's dual-edge bit is 1, the line latches on both edges and its type and polarity bits have no effect. A level-low line with its input low therefore shows no status.
- R6: A write of wdata to address 0x078 clears the latch of every line whose wdata bit is 1 and leaves the other lines' latches unchanged. If the same line sees a new edge event in that cycle, the latch stays set.
- R7: A line whose enable bit is 0 shows no status and latches no new edge event. Setting the enable bit later does not reveal an event that occurred while the line was disabled.
- R8: A line whose mask bit is 1 shows no status, but its latched edge is kept. Clearing the mask bit shows the latched edge again.
- R9: irq_o is a register. It is 1 in the cycle after a clock edge at which the combine enable (bit 0 of address 0x0a0, written directly) is 1 and at least one status bit is set. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | LINES | Synchronized GPIO input levels |
| wr_en_i | input | 1 | Register write strobe |
| waddr_i | input | 8 | Register write address |
| wdata_i | input | LINES | Register write data |
| raddr_i | input | 8 | Register read address |
| rdata_o | output | LINES | Read data: status at 0x070, dual-edge word at 0x0b8, 0 elsewhere |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same clock cycle as a new qualifying edge on the same line. To reach it, the bench first latches an edge and returns the line to its idle level. It then drives the next rising transition and the acknowledge write at the same negative clock edge, so both are sampled together. The bench also checks that edges seen while a line is disabled or masked behave differently: a masked edge stays latched and appears once the mask is cleared, while an edge seen while disabled is never latched. The dual-edge priority is checked by putting a line in level-low mode with its input low, where it would otherwise be active.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int NUM_CFG = 5;

  typedef enum int {CFG_EN = 0, CFG_MASK = 1, CFG_TYPE = 2, CFG_POL = 3, CFG_DUAL = 4} cfg_idx_e;

  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 8'h70;
  localparam logic [ADDR_W-1:0] ADDR_ACK     = 8'h78;
  localparam logic [ADDR_W-1:0] ADDR_COMB    = 8'ha0;
  localparam logic [ADDR_W-1:0] ADDR_DUAL_RD = 8'hb8;

  function automatic logic [ADDR_W-1:0] cfg_set_addr(int idx);
    case (idx)
      CFG_EN:   return 8'h20;
      CFG_MASK: return 8'h30;
      CFG_TYPE: return 8'h40;
      CFG_POL:  return 8'h50;
      default:  return 8'hb0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] cfg_clr_addr(int idx);
    return cfg_set_addr(idx) + 8'h04;
  endfunction
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg
  import gpio_irq_pkg::*;
#(
  parameter int W = 32,
  parameter logic [ADDR_W-1:0] SET_ADDR = 8'h20,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (wr_en_i && waddr_i == SET_ADDR) q <= q | wdata_i;
    else if (wr_en_i && waddr_i == CLR_ADDR) q <= q & ~wdata_i;
  end

  assign q_o = q;

  // R2
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && waddr_i == SET_ADDR) |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));
  // R2
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && waddr_i == CLR_ADDR) |=> ((q_o & $past(wdata_i)) == '0));
  // R2
  keep_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (waddr_i == SET_ADDR || waddr_i == CLR_ADDR))
      |=> ((q_o & ~$past(wdata_i)) == ($past(q_o) & ~$past(wdata_i))));
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic en_i,
  input  logic edge_i,
  input  logic pol_i,
  input  logic dual_i,
  input  logic ack_i,
  output logic raw_o
);
  logic prev_q, latch_q;
  logic rise, fall, evt, set;

  assign rise = line_i & ~prev_q;
  assign fall = ~line_i & prev_q;
  // dual-edge takes priority over type/polarity
  assign evt  = dual_i ? (rise | fall) : (edge_i & (pol_i ? rise : fall));
  assign set  = en_i & evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      if (set) latch_q <= 1'b1;
      else if (ack_i) latch_q <= 1'b0;
    end
  end

  assign raw_o = (dual_i | edge_i) ? latch_q : (pol_i ? line_i : ~line_i);

  // R6
  edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && en_i && evt) |=> latch_q);
  // R6
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(en_i && evt)) |=> !latch_q);
  // R4
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !ack_i) |=> latch_q);
  // R7
  no_new_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !latch_q) |=> !latch_q);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  line_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LINES-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [LINES-1:0]  rdata_o,
  output logic              irq_o
);
  logic [NUM_CFG-1:0][LINES-1:0] cfg;
  logic [LINES-1:0] ack, raw, status;
  logic comb_q, irq_q;

  for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
    gpio_setclr_reg #(
      .W(LINES), .SET_ADDR(cfg_set_addr(c)), .CLR_ADDR(cfg_clr_addr(c))
    ) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
      .waddr_i(waddr_i), .wdata_i(wdata_i), .q_o(cfg[c])
    );
  end

  assign ack = (wr_en_i && waddr_i == ADDR_ACK) ? wdata_i : '0;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    gpio_line_detect u_det (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i[i]),
      .en_i(cfg[CFG_EN][i]), .edge_i(cfg[CFG_TYPE][i]), .pol_i(cfg[CFG_POL][i]),
      .dual_i(cfg[CFG_DUAL][i]), .ack_i(ack[i]), .raw_o(raw[i])
    );
  end

  assign status = raw & cfg[CFG_EN] & ~cfg[CFG_MASK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comb_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en_i && waddr_i == ADDR_COMB) comb_q <= wdata_i[0];
      irq_q <= comb_q & (|status);
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    case (raddr_i)
      ADDR_STATUS:  rdata_o = status;
      ADDR_DUAL_RD: rdata_o = cfg[CFG_DUAL];
      default:      rdata_o = '0;
    endcase
  end

  // R9
  comb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !comb_q |=> !irq_o);
  // R9
  no_status_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status == '0) |=> !irq_o);
endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] line = '0, wdata = '0, rdata;
  logic wr = 0, irq;
  logic [7:0] waddr = '0, raddr = 8'h70;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gpio_irq_unit #(.LINES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .wr_en_i(wr), .waddr_i(waddr),
    .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [N-1:0] d);
    raddr = a; #1 d = rdata;
  endtask

  task automatic chk_status(string req, logic [N-1:0] exp);
    logic [N-1:0] d;
    rd(8'h70, d);
    chk(req, d, exp);
  endtask

  task automatic wreg(logic [7:0] a, logic [N-1:0] d);
    @(negedge clk); wr = 1; waddr = a; wdata = d;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic drive(int i, logic v);
    @(negedge clk); line[i] = v;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    logic [N-1:0] d;
    chk_status("R1 status", '0);
    rd(8'hb8, d); chk("R1 dual", d, '0);
    chk("R1 irq", {31'b0, irq}, '0);
  endtask

  task automatic t_setclr;
    logic [N-1:0] d;
    wreg(8'hb0, 32'hF0); rd(8'hb8, d); chk("R2 set", d, 32'hF0);
    wreg(8'hb0, 32'h03); rd(8'hb8, d); chk("R2 set keep", d, 32'hF3);
    wreg(8'hb4, 32'h30); rd(8'hb8, d); chk("R2 clr", d, 32'hC3);
    wreg(8'hb4, '1);     rd(8'hb8, d); chk("R2 clr all", d, '0);
  endtask

  task automatic t_level;
    wreg(8'h20, 32'h1); wreg(8'h50, 32'h1);
    @(negedge clk); line[0] = 1; #1 chk_status("R3 high", 32'h1);
    @(negedge clk); line[0] = 0; #1 chk_status("R3 not latched", 32'h0);
    wreg(8'h54, 32'h1); chk_status("R3 low active", 32'h1);
    wreg(8'h24, 32'h1); chk_status("R7 disabled level", 32'h0);
  endtask

  task automatic t_edge;
    wreg(8'h40, 32'h2); wreg(8'h50, 32'h2); wreg(8'h20, 32'h2);
    drive(1, 1); chk_status("R4 rise latched", 32'h2);
    drive(1, 0); chk_status("R4 held", 32'h2);
    wreg(8'h78, 32'h2); chk_status("R6 ack", 32'h0);
    wreg(8'h54, 32'h2);
    drive(1, 1); chk_status("R4 rise ignored fall mode", 32'h0);
    drive(1, 0); chk_status("R4 fall latched", 32'h2);
    wreg(8'h78, 32'h2); wreg(8'h24, 32'h2);
    chk_status("R4 cleared", 32'h0);
  endtask

  task automatic t_dual;
    wreg(8'hb0, 32'h4); wreg(8'h20, 32'h4);
    chk_status("R5 overrides level-low", 32'h0);
    drive(2, 1); chk_status("R5 rise", 32'h4);
    wreg(8'h78, 32'h4); chk_status("R5 ack", 32'h0);
    drive(2, 0); chk_status("R5 fall", 32'h4);
    wreg(8'h78, 32'h4);
    wreg(8'hb4, 32'h4); chk_status("R5 revert to level-low", 32'h4);
    wreg(8'h24, 32'h4); chk_status("R5 off", 32'h0);
  endtask

  task automatic t_ack;
    wreg(8'h40, 32'h8); wreg(8'h50, 32'h8); wreg(8'h20, 32'h8);
    drive(3, 1); drive(3, 0);
    chk_status("R6 first edge", 32'h8);
    @(negedge clk); line[3] = 1; wr = 1; waddr = 8'h78; wdata = 32'h8;
    @(posedge clk); #1 wr = 0;
    chk_status("R6 edge wins over ack", 32'h8);
    wreg(8'h78, 32'h10); chk_status("R6 other bit ack", 32'h8);
    wreg(8'h78, 32'h8);  chk_status("R6 ack clears", 32'h0);
    wreg(8'h24, 32'h8);
  endtask

  task automatic t_enable;
    wreg(8'h40, 32'h10); wreg(8'h50, 32'h10);
    drive(4, 1); chk_status("R7 disabled", 32'h0);
    wreg(8'h20, 32'h10); chk_status("R7 no stale event", 32'h0);
    drive(4, 0); drive(4, 1); chk_status("R7 enabled edge", 32'h10);
    wreg(8'h78, 32'h10); wreg(8'h24, 32'h10);
  endtask

  task automatic t_mask;
    wreg(8'h40, 32'h20); wreg(8'h50, 32'h20); wreg(8'h20, 32'h20); wreg(8'h30, 32'h20);
    drive(5, 1); chk_status("R8 masked hidden", 32'h0);
    wreg(8'h34, 32'h20); chk_status("R8 unmask shows latch", 32'h20);
    wreg(8'h78, 32'h20); wreg(8'h24, 32'h20);
    chk_status("R8 cleared", 32'h0);
  endtask

  task automatic t_comb;
    wreg(8'h50, 32'h40); wreg(8'h20, 32'h40);
    @(negedge clk); line[6] = 1;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 gated off", {31'b0, irq}, 0);
    wreg(8'ha0, 32'h1);
    chk("R9 one cycle later", {31'b0, irq}, 0);
    @(posedge clk); #1 chk("R9 raised", {31'b0, irq}, 1);
    @(negedge clk); line[6] = 0; #1;
    chk("R9 still registered", {31'b0, irq}, 1);
    @(posedge clk); #1 chk("R9 dropped", {31'b0, irq}, 0);
    wreg(8'ha0, 32'h0); wreg(8'h24, 32'h40);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=done");
      summary();
    end
  end

  initial begin
    #20 rst_n = 1;
    @(negedge clk);
    t_reset(); t_setclr(); t_level(); t_edge(); t_dual();
    t_ack(); t_enable(); t_mask(); t_comb();
    finished = 1;
    summary();
  end
endmodule